// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A memory-mapped watchdog built around a 32-bit down-counter. Software programs a reload value into a timeout register and turns the watchdog on through a control register. The count then drops by one each clock. To keep the system alive, software refreshes the counter by writing two fixed key words to a service register. The first key word is 0x0000A602 and the second is 0x0000B480. If the counter runs out while the watchdog is on, a sticky expiry output goes high and stays high until reset.

Separate control bits decide how the counter reacts to a debug-halt input and to a low-power-stop input. Each bit lets the matching input pause the count. Any reload value below 0x100 is raised to 0x100 when it is loaded into the counter. The current count can be read over the register bus, but only while the watchdog is off. The register bus is a simple slave: one address, a write strobe, write data, and combinational read data. A write takes effect on the clock edge where the strobe is high. Reset is synchronous and active high.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, the control register reads 0, the timeout register reads 0x00001000, the count readback reads 0, and `wdg_expired` is low.
- R2: The control register sits at offset 0x00. Bit 0 enables the watchdog. Bit 1 allows debug freeze. Bit 2 allows the pause in low-power stop. Bits 10:9 select the service mode. These bits read back as written and all other bits read 0. Every mode value behaves as fixed-key mode.
- R3: A control write that sets bit 0 while the watchdog is off loads the counter on that edge. The counter then drops by one on every later edge while enabled and not paused. The edge of the disabling write also counts.
- R4: The timeout register at offset 0x08 reads back the raw written value. The counter is loaded with the larger of that value and 0x100.
- R5: Writing the timeout register while the watchdog is on does not change the running count.
- R6: Writing key 0x0000A602 and then key 0x0000B480 to offset 0x10, with no other service write between them, reloads the counter on the second write's edge. This holds for any mode value.
- R7: A service write of any other value clears the key tracker, so a later 0x0000B480 alone does not reload. A repeated 0x0000A602 keeps the tracker armed.
- R8: A complete key sequence written while the watchdog is off leaves the count unchanged.
- R9: Offset 0x14 returns the count while the watchdog is off and returns 0 while it is on.
- R10: With bit 1 set, `dbg_halt` high pauses the count. With bit 1 clear, `dbg_halt` has no effect.
- R11: With bit 2 set, `lp_stop` high pauses the count. With bit 2 clear, `lp_stop` has no effect.
- R12: `wdg_expired` rises on the edge after the counter reaches 0 while enabled. It then stays high, even after the watchdog is disabled, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| dbg_halt | input | 1 | Debug halt indication |
| lp_stop | input | 1 | Low-power stop indication |
| wdg_expired | output | 1 | Sticky expiry flag |

## Verification
The assertions assume that the pause inputs and the bus signals are steady around each rising edge. They also assume that a load never coincides with a disabled counter, because loads only come from enabling or from a key sequence while enabled. The stimulus changes every input only on falling edges. It checks the count only by disabling the watchdog and reading offset 0x14, so the expected value is the loaded value minus the counted edges, including the disabling edge. Reload values stay at 0x100 or more, or are clamped to that, and gaps stay short, so no check runs into an expiry except the one test meant to reach it.

// File: rtl/svc_wdg_pkg.sv
package svc_wdg_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned ADDR_W = 8;
    parameter int unsigned MODE_W = 2;

    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_TMO  = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFF_SVC  = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(8'h14);

    localparam logic [DATA_W-1:0] KEY_FIRST  = DATA_W'(32'h0000_A602);
    localparam logic [DATA_W-1:0] KEY_SECOND = DATA_W'(32'h0000_B480);
    localparam logic [DATA_W-1:0] LOAD_FLOOR = DATA_W'(32'h0000_0100);

    localparam int unsigned BIT_EN      = 0;
    localparam int unsigned BIT_DBGFRZ  = 1;
    localparam int unsigned BIT_STOPHLD = 2;
    localparam int unsigned BIT_MODE_LO = 9;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              stop_hold;
        logic              dbg_frz;
        logic              enable;
    } ctrl_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } keyst_e;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_EN]                  = c.enable;
        w[BIT_DBGFRZ]              = c.dbg_frz;
        w[BIT_STOPHLD]             = c.stop_hold;
        w[BIT_MODE_LO +: MODE_W]   = c.mode;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.enable    = w[BIT_EN];
        c.dbg_frz   = w[BIT_DBGFRZ];
        c.stop_hold = w[BIT_STOPHLD];
        c.mode      = w[BIT_MODE_LO +: MODE_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] clamp_load(
        input logic [DATA_W-1:0] raw,
        input logic [DATA_W-1:0] floor_v
    );
        return (raw < floor_v) ? floor_v : raw;
    endfunction

endpackage

// File: rtl/svc_wdg_regs.sv
module svc_wdg_regs
    import svc_wdg_pkg::*;
#(
    parameter logic [DATA_W-1:0] TMO_RESET = DATA_W'(32'h0000_1000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] cnt_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] tmo_o,
    output logic              en_rise_o,
    output logic              svc_wr_o,
    output logic [DATA_W-1:0] rdata_o
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] tmo_q;
    logic              ctrl_wr;
    logic              tmo_wr;

    assign ctrl_wr  = we_i && (addr_i == OFF_CTRL);
    assign tmo_wr   = we_i && (addr_i == OFF_TMO);
    assign svc_wr_o = we_i && (addr_i == OFF_SVC);

    assign en_rise_o = ctrl_wr && wdata_i[BIT_EN] && !ctrl_q.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tmo_q  <= TMO_RESET;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= word_to_ctrl(wdata_i);
            end
            if (tmo_wr) begin
                tmo_q <= wdata_i;
            end
        end
    end

    always_comb begin
        unique case (addr_i)
            OFF_CTRL: rdata_o = ctrl_to_word(ctrl_q);
            OFF_TMO:  rdata_o = tmo_q;
            OFF_CNT:  rdata_o = ctrl_q.enable ? '0 : cnt_i;
            default:  rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign tmo_o  = tmo_q;

    // R2
    ctrl_wb_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_to_word(ctrl_q) == ($past(wdata_i) & ctrl_to_word('1))));

endmodule

// File: rtl/svc_wdg_keyseq.sv
module svc_wdg_keyseq
    import svc_wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_wr_i,
    input  logic [DATA_W-1:0] svc_data_i,
    output logic              match_o
);

    keyst_e state_q;
    keyst_e state_d;

    always_comb begin
        state_d = state_q;
        match_o = 1'b0;
        if (svc_wr_i) begin
            if ((state_q == KS_ARMED) && (svc_data_i == KEY_SECOND)) begin
                match_o = 1'b1;
                state_d = KS_IDLE;
            end else if (svc_data_i == KEY_FIRST) begin
                state_d = KS_ARMED;
            end else begin
                state_d = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R6
    seq_done_chk: assert property (@(posedge clk) disable iff (rst)
        match_o |=> (state_q == KS_IDLE));

    // R7
    first_key_arms_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_wr_i && svc_data_i == KEY_FIRST) |=> (state_q == KS_ARMED));

endmodule

// File: rtl/svc_wdg_counter.sv
module svc_wdg_counter
    import svc_wdg_pkg::*;
#(
    parameter logic [DATA_W-1:0] MIN_LOAD = LOAD_FLOOR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              hold_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              expired_o
);

    logic [DATA_W-1:0] cnt_q;
    logic              expired_q;
    logic              at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
        end else begin
            if (load_i) begin
                cnt_q <= load_val_i;
            end else if (en_i && !hold_i && !at_zero) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (en_i && at_zero && !load_i) begin
                expired_q <= 1'b1;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign expired_o = expired_q;

    // R3
    load_takes_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i)));

    // R4
    load_floor_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q >= MIN_LOAD));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !hold_i && !load_i && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R10
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && hold_i && !load_i) |=> $stable(cnt_q));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(cnt_q));

    // R12
    sticky_exp_chk: assert property (@(posedge clk) disable iff (rst)
        expired_q |=> expired_q);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_wdg_pkg::*;
#(
    parameter logic [DATA_W-1:0] TMO_RESET = DATA_W'(32'h0000_1000),
    parameter logic [DATA_W-1:0] MIN_LOAD  = LOAD_FLOOR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_halt,
    input  logic              lp_stop,
    output logic              wdg_expired
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] tmo_raw;
    logic [DATA_W-1:0] cnt;
    logic              en_rise;
    logic              svc_wr;
    logic              key_match;
    logic              load;
    logic              hold;

    svc_wdg_regs #(
        .TMO_RESET (TMO_RESET)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (bus_addr),
        .we_i      (bus_we),
        .wdata_i   (bus_wdata),
        .cnt_i     (cnt),
        .ctrl_o    (ctrl),
        .tmo_o     (tmo_raw),
        .en_rise_o (en_rise),
        .svc_wr_o  (svc_wr),
        .rdata_o   (bus_rdata)
    );

    svc_wdg_keyseq u_keyseq (
        .clk        (clk),
        .rst        (rst),
        .svc_wr_i   (svc_wr),
        .svc_data_i (bus_wdata),
        .match_o    (key_match)
    );

    assign load = en_rise || (key_match && ctrl.enable);
    assign hold = (ctrl.dbg_frz && dbg_halt) || (ctrl.stop_hold && lp_stop);

    svc_wdg_counter #(
        .MIN_LOAD (MIN_LOAD)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .en_i       (ctrl.enable),
        .hold_i     (hold),
        .load_i     (load),
        .load_val_i (clamp_load(tmo_raw, MIN_LOAD)),
        .cnt_o      (cnt),
        .expired_o  (wdg_expired)
    );

    // R9
    cnt_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && bus_addr == OFF_CNT) |-> (bus_rdata == '0));

    // R5
    tmo_no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_TMO && ctrl.enable) |-> !load);

endmodule

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        lp_stop = 1'b0;
    logic        wdg_expired;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam logic [7:0]  A_CTRL = 8'h00;
    localparam logic [7:0]  A_TMO  = 8'h08;
    localparam logic [7:0]  A_SVC  = 8'h10;
    localparam logic [7:0]  A_CNT  = 8'h14;
    localparam logic [31:0] K1     = 32'h0000_A602;
    localparam logic [31:0] K2     = 32'h0000_B480;

    typedef struct packed {
        logic [31:0] tmo;
        logic [7:0]  gap;
        logic [31:0] expect_cnt;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{32'h0000_0100, 8'd0,  32'h0000_00FF},
        '{32'h0000_0010, 8'd3,  32'h0000_00FC},
        '{32'h0000_0000, 8'd10, 32'h0000_00F5},
        '{32'h0000_1000, 8'd5,  32'h0000_0FFA},
        '{32'h0000_00FF, 8'd0,  32'h0000_00FF},
        '{32'h0000_0101, 8'd1,  32'h0000_00FF}
    };

    svc_watchdog u_svc_watchdog (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .dbg_halt    (dbg_halt),
        .lp_stop     (lp_stop),
        .wdg_expired (wdg_expired)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_TMO, v);  check("R1 timeout", v, 32'h0000_1000);
        rd(A_CNT, v);  check("R1 count", v, 32'h0);
        check("R1 expired", {31'b0, wdg_expired}, 32'h0);

        // R2 field read-back and masking
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, v); check("R2 ctrl mask", v, 32'h0000_0606);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); check("R2 ctrl clear", v, 32'h0);

        // R3 R4 vector table: load, clamp, count
        for (int i = 0; i < NVEC; i++) begin
            wr(A_TMO, VECS[i].tmo);
            wr(A_CTRL, 32'h1);
            idle(int'(VECS[i].gap));
            wr(A_CTRL, 32'h0);
            rd(A_CNT, v); check("R3 R4 count after run", v, VECS[i].expect_cnt);
            rd(A_TMO, v); check("R4 raw timeout", v, VECS[i].tmo);
        end

        // R5 timeout write while running does not reload
        wr(A_TMO, 32'h0000_0200);
        wr(A_CTRL, 32'h1);
        wr(A_TMO, 32'h0000_0100);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); check("R5 count", v, 32'h0000_01FE);
        rd(A_TMO, v); check("R5 new timeout", v, 32'h0000_0100);

        // R6 valid sequence reloads, mode 11 still fixed-key
        wr(A_CTRL, 32'h0000_0601);
        idle(4);
        wr(A_SVC, K1);
        wr(A_SVC, K2);
        idle(2);
        wr(A_CTRL, 32'h0000_0600);
        rd(A_CNT, v);  check("R6 reload", v, 32'h0000_00FD);
        rd(A_CTRL, v); check("R2 mode readback", v, 32'h0000_0600);
        wr(A_CTRL, 32'h0);

        // R7 broken sequence does not reload
        wr(A_CTRL, 32'h1);
        wr(A_SVC, K2);
        wr(A_SVC, K1);
        wr(A_SVC, 32'h0000_1234);
        wr(A_SVC, K2);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); check("R7 no reload", v, 32'h0000_00FB);

        // R7 repeated first key stays armed
        wr(A_CTRL, 32'h1);
        wr(A_SVC, K1);
        wr(A_SVC, K1);
        wr(A_SVC, K2);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); check("R7 rearm reload", v, 32'h0000_00FF);

        // R8 sequence while disabled has no effect
        wr(A_TMO, 32'h0000_0300);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_SVC, K1);
        wr(A_SVC, K2);
        rd(A_CNT, v); check("R8 disabled svc", v, 32'h0000_02FF);

        // R9 count hidden while enabled
        wr(A_TMO, 32'h0000_0100);
        wr(A_CTRL, 32'h1);
        rd(A_CNT, v); check("R9 hidden", v, 32'h0);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); check("R9 visible", v, 32'h0000_00FF);

        // R10 debug freeze
        wr(A_CTRL, 32'h3);
        dbg_halt = 1'b1;
        idle(5);
        dbg_halt = 1'b0;
        wr(A_CTRL, 32'h2);
        rd(A_CNT, v); check("R10 frozen", v, 32'h0000_00FF);
        wr(A_CTRL, 32'h1);
        dbg_halt = 1'b1;
        idle(5);
        wr(A_CTRL, 32'h0);
        dbg_halt = 1'b0;
        rd(A_CNT, v); check("R10 ignored", v, 32'h0000_00FA);

        // R11 low-power stop pause
        wr(A_CTRL, 32'h5);
        lp_stop = 1'b1;
        idle(7);
        lp_stop = 1'b0;
        wr(A_CTRL, 32'h4);
        rd(A_CNT, v); check("R11 paused", v, 32'h0000_00FF);
        wr(A_CTRL, 32'h1);
        lp_stop = 1'b1;
        idle(7);
        wr(A_CTRL, 32'h0);
        lp_stop = 1'b0;
        rd(A_CNT, v); check("R11 ignored", v, 32'h0000_00F8);

        // R12 expiry timing and stickiness
        wr(A_TMO, 32'h0000_0010);
        wr(A_CTRL, 32'h1);
        idle(256);
        check("R12 not yet", {31'b0, wdg_expired}, 32'h0);
        idle(1);
        check("R12 rises", {31'b0, wdg_expired}, 32'h1);
        wr(A_CTRL, 32'h0);
        idle(3);
        check("R12 sticky", {31'b0, wdg_expired}, 32'h1);
        rd(A_CNT, v); check("R12 count zero", v, 32'h0);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check("R12 cleared by reset", {31'b0, wdg_expired}, 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule